// File: doc/BRIEF.md
# Pending-Interrupt Collector with Write-One-to-Clear Status

This block gathers a small group of synchronous interrupt requests, remembers each one in a pending bit, and drives one active-high level output toward a parent interrupt controller. The output is high while at least one source is both pending and enabled. Software reaches the block over a plain 32-bit register bus. Each access carries a byte address, a write strobe and write data, and read data comes back combinationally.

Two register layouts are available, chosen by a build-time parameter. In the shared layout, one word at offset 0x0 carries the enables in its low half and the pending bits in its high half. Each pending bit sits exactly 16 positions above its own enable. Software can then rewrite only the enables by writing zeros in the upper half, and no pending request is lost. In the separate layout, enables and pending bits live in two words at offsets 0x0 and 0x4, and a parameter decides which word sits at which offset. The implemented sources always occupy a contiguous run of bit positions that starts at a configurable first bit.

Top module: `irq_gather`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, and `irq_o` is low.
- R2: A 0-to-1 change on `src_i[i]` sets pending bit i at the next clock edge, whatever its enable. A source held high does not set its pending bit again after that bit has been cleared.
- R3: With SPLIT_LAYOUT=0, reading offset 0x0 returns enable bit i at position SRC_LSB+i and pending bit i at position SRC_LSB+i+16, so each pending bit sits 16 bits above its enable.
- R4: With SPLIT_LAYOUT=0, a write to offset 0x0 loads the enables from bits 15:0. A 1 at bit SRC_LSB+i+16 clears pending bit i, and a 0 there leaves it unchanged.
- R5: With SPLIT_LAYOUT=1, the enable word sits at offset 0x4 when ENABLE_AT_4=1 and otherwise at 0x0, with the pending word at the other offset. Both words use bit position SRC_LSB+i for source i, and their bits 31:16 read as 0.
- R6: With SPLIT_LAYOUT=1, writing 1 to a bit of the pending word clears that bit and writing 0 leaves it unchanged. A write to the enable word does not change any pending bit.
- R7: `irq_o` is high in the same cycle that any source has both its pending bit and its enable bit set. It stays high until software has cleared or disabled every such source.
- R8: A pending bit whose enable is 0 stays pending, and it raises `irq_o` right after the write that sets its enable.
- R9: When a new rising edge on a source and a clearing write for that same source land on the same clock edge, the pending bit ends up set.
- R10: Enable and pending bits outside the implemented range read as 0 and ignore writes. Offsets with no register, and accesses whose address bits 1:0 are not zero, read as 0 and change nothing.
- R11: Reads have no side effects: reading a word repeatedly returns the same value and leaves every pending bit in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | SRC_COUNT | Interrupt requests, synchronous to clk |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
All state in the block changes at exactly one clock edge after its cause. A write or a source edge applied before edge N is visible in the read data and in `irq_o` just after edge N. Read data and `irq_o` follow the registers through logic only, with no extra stage. The bench therefore drives every input on the falling edge and samples one falling edge later, so each check lands in the first cycle the result is due. Read addresses are applied on a falling edge and sampled a nanosecond later, well inside the same low phase. The same-edge case (R9) is built by driving the source edge and the clearing write on the same falling edge.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

    // Enables and pending bits kept in a 16-bit "enable space"
    typedef struct packed {
        logic [15:0] en;
        logic [15:0] st;
    } irqg_state_t;

    // Bits SRC_LSB .. SRC_LSB+SRC_COUNT-1 set
    function automatic logic [15:0] impl_mask(input int lsb, input int count);
        logic [15:0] m;
        m = '0;
        for (int b = 0; b < 16; b++) begin
            if (b >= lsb && b < lsb + count) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irqg_edge.sv
module irqg_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
        rise_o = src_i & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irqg_core.sv
module irqg_core
    import irqg_pkg::*;
#(
    parameter int SRC_LSB   = 4,
    parameter int SRC_COUNT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] ev_i,
    input  logic                 en_wr_i,
    input  logic [15:0]          en_val_i,
    input  logic                 st_wr_i,
    input  logic [15:0]          st_clr_i,
    output logic [15:0]          en_o,
    output logic [15:0]          st_o
);
    localparam logic [15:0] MASK = impl_mask(SRC_LSB, SRC_COUNT);

    irqg_state_t s_d, s_q;
    logic [15:0] ev_w;

    // Place source events at their bit positions
    for (genvar g = 0; g < 16; g++) begin : g_place
        if (g >= SRC_LSB && g < SRC_LSB + SRC_COUNT) begin : g_on
            assign ev_w[g] = ev_i[g - SRC_LSB];
        end else begin : g_off
            assign ev_w[g] = 1'b0;
        end
    end

    always_comb begin
        s_d = s_q;
        if (en_wr_i) s_d.en = en_val_i & MASK;
        // clear first, then set: a same-edge event wins
        s_d.st = ((s_q.st & ~(st_wr_i ? st_clr_i : 16'h0)) | ev_w) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign en_o = s_q.en;
    assign st_o = s_q.st;

    // R2
    ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_w != 16'h0) |=> ((s_q.st & $past(ev_w)) == $past(ev_w)));

    // R2
    st_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((s_q.st & ~$past(s_q.st)) & ~$past(ev_w)) == 16'h0));

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_i |=> ((s_q.st & $past(st_clr_i & ~ev_w)) == 16'h0));

    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(s_q.en));
endmodule

// File: rtl/irqg_rdmux.sv
module irqg_rdmux #(
    parameter bit SPLIT_LAYOUT = 1'b0,
    parameter bit ENABLE_AT_4  = 1'b0,
    parameter int WORD_W       = 2
) (
    input  logic              rd_ok_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [15:0]       en_i,
    input  logic [15:0]       st_i,
    output logic [31:0]       rdata_o
);
    localparam logic [WORD_W-1:0] EN_WORD = ENABLE_AT_4 ? WORD_W'(1) : WORD_W'(0);
    localparam logic [WORD_W-1:0] ST_WORD = ENABLE_AT_4 ? WORD_W'(0) : WORD_W'(1);

    always_comb begin
        rdata_o = 32'h0;
        if (rd_ok_i) begin
            if (!SPLIT_LAYOUT) begin
                if (word_i == WORD_W'(0)) rdata_o = {st_i, en_i};
            end else begin
                if (word_i == EN_WORD)      rdata_o = {16'h0, en_i};
                else if (word_i == ST_WORD) rdata_o = {16'h0, st_i};
            end
        end
    end
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
    parameter bit SPLIT_LAYOUT = 1'b0,
    parameter bit ENABLE_AT_4  = 1'b0,
    parameter int SRC_LSB      = 4,
    parameter int SRC_COUNT    = 2,
    parameter int ADDR_W       = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] src_i,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_o
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] EN_WORD = ENABLE_AT_4 ? WORD_W'(1) : WORD_W'(0);
    localparam logic [WORD_W-1:0] ST_WORD = ENABLE_AT_4 ? WORD_W'(0) : WORD_W'(1);

    logic [SRC_COUNT-1:0] rise;
    logic [WORD_W-1:0]    word;
    logic                 aligned, en_wr, st_wr;
    logic [15:0]          st_clr, en_q, st_q;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);

    always_comb begin
        if (!SPLIT_LAYOUT) begin
            en_wr = bus_we && aligned && (word == WORD_W'(0));
            st_wr = en_wr;
        end else begin
            en_wr = bus_we && aligned && (word == EN_WORD);
            st_wr = bus_we && aligned && (word == ST_WORD);
        end
        st_clr = SPLIT_LAYOUT ? bus_wdata[15:0] : bus_wdata[31:16];
    end

    irqg_edge #(.N(SRC_COUNT)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .rise_o (rise)
    );

    irqg_core #(.SRC_LSB(SRC_LSB), .SRC_COUNT(SRC_COUNT)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (rise),
        .en_wr_i  (en_wr),
        .en_val_i (bus_wdata[15:0]),
        .st_wr_i  (st_wr),
        .st_clr_i (st_clr),
        .en_o     (en_q),
        .st_o     (st_q)
    );

    irqg_rdmux #(.SPLIT_LAYOUT(SPLIT_LAYOUT), .ENABLE_AT_4(ENABLE_AT_4), .WORD_W(WORD_W)) u_rd (
        .rd_ok_i (aligned),
        .word_i  (word),
        .en_i    (en_q),
        .st_i    (st_q),
        .rdata_o (bus_rdata)
    );

    assign irq_o = |(en_q & st_q);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(bus_we));
endmodule

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // u0: shared layout, sources at bits 5:4
    logic [1:0]  src0 = '0;
    logic [3:0]  addr0 = '0;
    logic        we0 = 1'b0;
    logic [31:0] wd0 = '0, rd0;
    logic        irq0;
    // u1: separate layout, enable word at 0x4, sources at bits 3:0
    logic [3:0]  src1 = '0;
    logic [3:0]  addr1 = '0;
    logic        we1 = 1'b0;
    logic [31:0] wd1 = '0, rd1;
    logic        irq1;

    int n_chk = 0, n_bad = 0;

    irq_gather u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src0), .bus_addr(addr0), .bus_we(we0),
        .bus_wdata(wd0), .bus_rdata(rd0), .irq_o(irq0)
    );

    irq_gather #(.SPLIT_LAYOUT(1'b1), .ENABLE_AT_4(1'b1), .SRC_LSB(0), .SRC_COUNT(4)) u1 (
        .clk(clk), .rst_n(rst_n), .src_i(src1), .bus_addr(addr1), .bus_we(we1),
        .bus_wdata(wd1), .bus_rdata(rd1), .irq_o(irq1)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr0(input logic [3:0] a, input logic [31:0] d);
        addr0 = a; wd0 = d; we0 = 1'b1;
        @(negedge clk);
        we0 = 1'b0;
    endtask

    task automatic wr1(input logic [3:0] a, input logic [31:0] d);
        addr1 = a; wd1 = d; we1 = 1'b1;
        @(negedge clk);
        we1 = 1'b0;
    endtask

    task automatic rdc0(input logic [3:0] a, output logic [31:0] v);
        addr0 = a; #1; v = rd0;
    endtask

    task automatic rdc1(input logic [3:0] a, output logic [31:0] v);
        addr1 = a; #1; v = rd1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rdc0(4'h0, v); chk("R1", "u0 word0 after reset", v, 32'h0);
        chk("R1", "u0 irq after reset", {31'h0, irq0}, 32'h0);
        rdc1(4'h0, v); chk("R1", "u1 pending after reset", v, 32'h0);
        rdc1(4'h4, v); chk("R1", "u1 enable after reset", v, 32'h0);
        chk("R1", "u1 irq after reset", {31'h0, irq1}, 32'h0);
    endtask

    task automatic t_masked_pending();
        logic [31:0] v;
        src0 = 2'b01; @(negedge clk); src0 = 2'b00;
        rdc0(4'h0, v); chk("R2", "masked edge latched", v, 32'h0010_0000);
        chk("R8", "masked pending keeps irq low", {31'h0, irq0}, 32'h0);
        wr0(4'h0, 32'h0000_0010);
        rdc0(4'h0, v); chk("R4", "enable-only write keeps pending", v, 32'h0010_0010);
        chk("R8", "irq after enabling pending source", {31'h0, irq0}, 32'h1);
    endtask

    task automatic t_w1c_shared();
        logic [31:0] v;
        src0 = 2'b10; @(negedge clk); src0 = 2'b00;
        wr0(4'h0, 32'h0000_0030);
        rdc0(4'h0, v); chk("R3", "status 16 above enable", v, 32'h0030_0030);
        wr0(4'h0, 32'h0010_0030);
        rdc0(4'h0, v); chk("R4", "clear one pending bit", v, 32'h0020_0030);
        chk("R7", "irq held while one pending left", {31'h0, irq0}, 32'h1);
        wr0(4'h0, 32'h0020_0030);
        rdc0(4'h0, v); chk("R4", "clear last pending bit", v, 32'h0000_0030);
        chk("R7", "irq drops after all cleared", {31'h0, irq0}, 32'h0);
    endtask

    task automatic t_outside();
        logic [31:0] v;
        wr0(4'h0, 32'hFFFF_FFFF);
        rdc0(4'h0, v); chk("R10", "unimplemented bits read zero", v, 32'h0000_0030);
        wr0(4'h4, 32'h0000_0000);
        rdc0(4'h4, v); chk("R10", "unmapped offset reads zero", v, 32'h0);
        rdc0(4'h0, v); chk("R10", "unmapped write ignored", v, 32'h0000_0030);
        wr0(4'h1, 32'h0000_0000);
        rdc0(4'h0, v); chk("R10", "unaligned write ignored", v, 32'h0000_0030);
        rdc0(4'h1, v); chk("R10", "unaligned read zero", v, 32'h0);
    endtask

    task automatic t_held_level();
        logic [31:0] v;
        src0 = 2'b01; @(negedge clk);
        rdc0(4'h0, v); chk("R2", "held level sets once", v, 32'h0010_0030);
        wr0(4'h0, 32'h0010_0030);
        @(negedge clk); @(negedge clk);
        rdc0(4'h0, v); chk("R2", "held level does not re-set", v, 32'h0000_0030);
        chk("R7", "irq low with held level cleared", {31'h0, irq0}, 32'h0);
        src0 = 2'b00; @(negedge clk);
    endtask

    task automatic t_race();
        logic [31:0] v;
        src0 = 2'b10; @(negedge clk); src0 = 2'b00; @(negedge clk);
        src0 = 2'b10; addr0 = 4'h0; wd0 = 32'h0020_0030; we0 = 1'b1;
        @(negedge clk);
        src0 = 2'b00; we0 = 1'b0;
        rdc0(4'h0, v); chk("R9", "edge beats same-edge clear", v, 32'h0020_0030);
        chk("R9", "irq stays high", {31'h0, irq0}, 32'h1);
    endtask

    task automatic t_read_clean();
        logic [31:0] a, b;
        rdc0(4'h0, a); @(negedge clk); @(negedge clk);
        rdc0(4'h0, b);
        chk("R11", "repeated read identical", b, a);
        chk("R11", "pending survives reads", b, 32'h0020_0030);
        wr0(4'h0, 32'h0020_0030);
        rdc0(4'h0, a); chk("R4", "final clear", a, 32'h0000_0030);
    endtask

    task automatic t_split();
        logic [31:0] v;
        wr1(4'h4, 32'hFFFF_FFFF);
        rdc1(4'h4, v); chk("R5", "enable word at 0x4", v, 32'h0000_000F);
        rdc1(4'h0, v); chk("R5", "pending word at 0x0 empty", v, 32'h0);
        src1 = 4'b0101; @(negedge clk); src1 = 4'b0000;
        rdc1(4'h0, v); chk("R5", "pending bits at enable positions", v, 32'h0000_0005);
        chk("R7", "split irq high", {31'h0, irq1}, 32'h1);
        wr1(4'h0, 32'h0000_0001);
        rdc1(4'h0, v); chk("R6", "split W1C one bit", v, 32'h0000_0004);
        wr1(4'h4, 32'h0000_0000);
        rdc1(4'h0, v); chk("R6", "enable write keeps pending", v, 32'h0000_0004);
        chk("R7", "split irq low when disabled", {31'h0, irq1}, 32'h0);
        wr1(4'h0, 32'hFFFF_FFFB);
        rdc1(4'h0, v); chk("R6", "zero bit leaves pending", v, 32'h0000_0004);
        wr1(4'h0, 32'h0000_0004);
        rdc1(4'h0, v); chk("R6", "split clear last", v, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_pending();
        t_w1c_shared();
        t_outside();
        t_held_level();
        t_race();
        t_read_clean();
        t_split();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule